// File: doc/BRIEF.md
# Descriptor Command Sequencer

This block steers one channel of a descriptor-driven DMA engine. Starting at a programmable command pointer, it reads a 16-byte little-endian descriptor from memory as three 32-bit words: the command word, the buffer address and the branch target. It decodes the 4-bit command code and either hands a transfer to an external data mover, completes the command at once, stops, or declares the channel dead. When a command finishes, the block writes status and, for transfers, the residual byte count back into the descriptor's last word. It then moves on, either to the next descriptor 16 bytes further or to the branch target.

A 2-bit branch mode in each descriptor decides whether the branch is taken. The mode can be never, always, when the condition holds, or when it fails. The condition compares the eight software status bits against a select value, using only the bits picked by a mask. A register port sets the status bits, the branch mask and value, and the command pointer. A start pulse launches the channel.

The sequencer is a six-state machine. ST_IDLE goes to ST_RD_CMD on a start pulse, unless the channel is dead. ST_RD_CMD, ST_RD_ADDR and ST_RD_BR read the three descriptor words. From ST_RD_BR the machine returns to ST_IDLE on stop or on an illegal command, goes to ST_XFER for a transfer command, or goes to ST_WB otherwise. ST_XFER leaves for ST_WB when the mover reports done. ST_WB writes back, updates the pointer and returns to ST_RD_CMD.

Top module: `desc_seq`

## Requirements
- R1: After reset, status is 0x0000, the command pointer is 0, and neither mem_req nor xfer_req is asserted.
- R2: A run_req pulse while idle and not dead sets ACTIVE (status bit 10) and reads the descriptor at the command pointer at byte offsets 0, 4 and 8, in that order. Memory is requested only while ACTIVE.
- R3: Command codes 0 to 3 (bits 31:28 of the command word) assert xfer_req, with xfer_addr taken from offset 4, xfer_len from bits 15:0 of the command word and xfer_code equal to the code. The request is held until xfer_done.
- R4: When a transfer command completes, offset 12 receives a full-word write: bits 15:0 carry the residual count returned by the mover, and bits 31:16 carry the status with ACTIVE set.
- R5: Codes 4, 5 and 6 make no transfer. They write only bytes 3:2 of offset 12 (byte enables 1100) with the status with ACTIVE set.
- R6: Branch mode 00 (bits 19:18 of the command word) never branches, and the pointer advances by 16.
- R7: Branch mode 11 always loads the pointer from descriptor offset 8.
- R8: Branch mode 01 branches when (status[7:0] & mask) == (value & mask), and mode 10 branches when it differs. The mask is bits 23:16 and the value bits 7:0 of the branch-select write.
- R9: Code 7 clears ACTIVE without any write-back and leaves the pointer at the stop descriptor.
- R10: Codes 8 to 15, or a transfer code with a nonzero key (bits 26:24), set DEAD (bit 11) and clear ACTIVE. DEAD lasts until reset, and start pulses are ignored while it is set.
- R11: A control write whose bits 7:0 differ from status[7:0] ORs them into status[7:0]. Bit 8 of a control write sets WAKE (status bit 8), and WAKE is cleared whenever a descriptor fetch begins.
- R12: Writes to the branch-select register (reg_addr 1) and the command pointer (reg_addr 2) are ignored while the channel is not idle. Control writes (reg_addr 0) are accepted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Start pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 branch select, 2 command pointer |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_code | output | 2 | Transfer kind (command code 0 to 3) |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | 16 | Requested byte count |
| xfer_done | input | 1 | Transfer complete pulse |
| xfer_resid | input | 16 | Residual byte count |
| status | output | 16 | Channel status word |
| cmd_ptr | output | ADDR_W | Current command pointer |

## Verification
The bench builds the block with the default 32-bit address width, so branch targets and buffer addresses reach the full word read from a descriptor. Because the block is built at full width, a short descriptor program in a 256-byte memory covers sequential stepping, taken and skipped branches in every mode, stop, and both illegal forms. A table walks eight mask, value and status combinations through all four branch modes. Directed programs then cover the transfer write-back, stop, the dead channel, the status OR rule with its WAKE clearing, and register writes ignored while active.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
    localparam int DESC_BYTES = 16;
    localparam int CNT_W      = 16;
    localparam int SBIT_W     = 8;

    localparam int ST_WAKE_BIT   = 8;
    localparam int ST_ACTIVE_BIT = 10;
    localparam int ST_DEAD_BIT   = 11;

    localparam logic [3:0] CODE_STOP = 4'd7;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_BRSEL = 2'd1;
    localparam logic [1:0] REG_PTR   = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_ADDR,
        ST_RD_BR,
        ST_XFER,
        ST_WB
    } seq_state_e;

    typedef enum logic [1:0] {
        BR_NEVER   = 2'b00,
        BR_IF_TRUE = 2'b01,
        BR_IF_FALSE= 2'b10,
        BR_ALWAYS  = 2'b11
    } br_mode_e;
endpackage

// File: rtl/desc_branch_eval.sv
module desc_branch_eval
    import desc_seq_pkg::*;
#(
    parameter int SEL_W = SBIT_W
) (
    input  logic [1:0]       br_mode,
    input  logic [SEL_W-1:0] stat_bits,
    input  logic [SEL_W-1:0] sel_mask,
    input  logic [SEL_W-1:0] sel_value,
    output logic             take
);
    logic match;

    assign match = (stat_bits & sel_mask) == (sel_value & sel_mask);

    always_comb begin
        unique case (br_mode_e'(br_mode))
            BR_NEVER:    take = 1'b0;
            BR_IF_TRUE:  take = match;
            BR_IF_FALSE: take = !match;
            BR_ALWAYS:   take = 1'b1;
        endcase
    end
endmodule

// File: rtl/desc_status_reg.sv
module desc_status_reg
    import desc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [8:0]  ctrl_data,
    input  logic        clr_wake,
    input  logic        set_active,
    input  logic        clr_active,
    input  logic        set_dead,
    output logic [15:0] stat_o
);
    logic [15:0] stat_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (ctrl_wr && (ctrl_data[SBIT_W-1:0] != stat_q[SBIT_W-1:0]))
            stat_d[SBIT_W-1:0] = stat_q[SBIT_W-1:0] | ctrl_data[SBIT_W-1:0];
        if (ctrl_wr && ctrl_data[8])
            stat_d[ST_WAKE_BIT] = 1'b1;
        if (clr_wake)
            stat_d[ST_WAKE_BIT] = 1'b0;
        if (set_active)
            stat_d[ST_ACTIVE_BIT] = 1'b1;
        if (clr_active)
            stat_d[ST_ACTIVE_BIT] = 1'b0;
        if (set_dead) begin
            stat_d[ST_DEAD_BIT]   = 1'b1;
            stat_d[ST_ACTIVE_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/desc_seq.sv
module desc_seq
    import desc_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [1:0]        xfer_code,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [CNT_W-1:0]  xfer_len,
    input  logic              xfer_done,
    input  logic [CNT_W-1:0]  xfer_resid,
    output logic [15:0]       status,
    output logic [ADDR_W-1:0] cmd_ptr
);
    localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BR   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_WB   = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DESC_BYTES);

    seq_state_e st_q, st_d;

    logic [ADDR_W-1:0] ptr_q, buf_addr_q, target_q;
    logic [3:0]        code_q;
    logic [2:0]        key_q;
    logic [1:0]        br_q;
    logic [CNT_W-1:0]  len_q, resid_q;
    logic [SBIT_W-1:0] br_mask_q, br_val_q;

    logic set_active, clr_active, set_dead, clr_wake;
    logic is_data, is_illegal, take;
    logic [15:0] wb_stat;
    logic unused_bits;

    assign unused_bits = ^{mem_rdata[27], mem_rdata[23:20], mem_rdata[17:16]};

    assign is_data    = (code_q[3:2] == 2'b00);
    assign is_illegal = code_q[3] || (is_data && (key_q != 3'd0));

    desc_status_reg u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (reg_wr && (reg_addr == REG_CTRL)),
        .ctrl_data  (reg_wdata[8:0]),
        .clr_wake   (clr_wake),
        .set_active (set_active),
        .clr_active (clr_active),
        .set_dead   (set_dead),
        .stat_o     (status)
    );

    desc_branch_eval #(.SEL_W(SBIT_W)) u_br (
        .br_mode   (br_q),
        .stat_bits (status[SBIT_W-1:0]),
        .sel_mask  (br_mask_q),
        .sel_value (br_val_q),
        .take      (take)
    );

    // next-state and status strobes
    always_comb begin
        st_d       = st_q;
        set_active = 1'b0;
        clr_active = 1'b0;
        set_dead   = 1'b0;
        clr_wake   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (run_req && !status[ST_DEAD_BIT]) begin
                    set_active = 1'b1;
                    st_d       = ST_RD_CMD;
                end
            end
            ST_RD_CMD: begin
                clr_wake = 1'b1;
                st_d     = ST_RD_ADDR;
            end
            ST_RD_ADDR: st_d = ST_RD_BR;
            ST_RD_BR: begin
                if (code_q == CODE_STOP) begin
                    clr_active = 1'b1;
                    st_d       = ST_IDLE;
                end else if (is_illegal) begin
                    set_dead = 1'b1;
                    st_d     = ST_IDLE;
                end else if (is_data) begin
                    st_d = ST_XFER;
                end else begin
                    st_d = ST_WB;
                end
            end
            ST_XFER: if (xfer_done) st_d = ST_WB;
            ST_WB:   st_d = ST_RD_CMD;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // descriptor fields, pointer and branch select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            buf_addr_q <= '0;
            target_q   <= '0;
            code_q     <= '0;
            key_q      <= '0;
            br_q       <= '0;
            len_q      <= '0;
            resid_q    <= '0;
            br_mask_q  <= '0;
            br_val_q   <= '0;
        end else begin
            if (st_q == ST_IDLE && reg_wr) begin
                if (reg_addr == REG_BRSEL) begin
                    br_mask_q <= reg_wdata[23:16];
                    br_val_q  <= reg_wdata[7:0];
                end
                if (reg_addr == REG_PTR)
                    ptr_q <= reg_wdata[ADDR_W-1:0];
            end
            unique case (st_q)
                ST_RD_CMD: begin
                    code_q <= mem_rdata[31:28];
                    key_q  <= mem_rdata[26:24];
                    br_q   <= mem_rdata[19:18];
                    len_q  <= mem_rdata[15:0];
                end
                ST_RD_ADDR: buf_addr_q <= mem_rdata[ADDR_W-1:0];
                ST_RD_BR:   target_q   <= mem_rdata[ADDR_W-1:0];
                ST_XFER:    if (xfer_done) resid_q <= xfer_resid;
                ST_WB:      ptr_q <= take ? target_q : ptr_q + STEP;
                default: ;
            endcase
        end
    end

    assign wb_stat = status | (16'd1 << ST_ACTIVE_BIT);

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_be    = 4'b0000;
        mem_wdata = '0;
        xfer_req  = 1'b0;
        unique case (st_q)
            ST_RD_CMD:  mem_req = 1'b1;
            ST_RD_ADDR: begin mem_req = 1'b1; mem_addr = ptr_q + OFS_ADDR; end
            ST_RD_BR:   begin mem_req = 1'b1; mem_addr = ptr_q + OFS_BR;   end
            ST_XFER:    xfer_req = 1'b1;
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + OFS_WB;
                mem_be    = is_data ? 4'b1111 : 4'b1100;
                mem_wdata = {wb_stat, is_data ? resid_q : 16'h0000};
            end
            default: ;
        endcase
    end

    assign xfer_code = code_q[1:0];
    assign xfer_addr = buf_addr_q;
    assign xfer_len  = len_q;
    assign cmd_ptr   = ptr_q;
endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status,
    input logic        mem_req,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        xfer_req
);
    assert_fetch_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> status[10]);

    assert_xfer_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (status[10] && !mem_req));

    assert_wb_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be[3:2] == 2'b11 && mem_wdata[26]));

    assert_dead_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[11] |-> !status[10]);

    assert_dead_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[11] |=> status[11]);
endmodule

bind desc_seq desc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .xfer_req  (xfer_req)
);

// File: tb/desc_seq_tb.sv
`timescale 1ns/1ps
module desc_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        xfer_req;
    logic [1:0]  xfer_code;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_len;
    logic        xfer_done = 1'b0;
    logic [15:0] xfer_resid = '0;
    logic [15:0] status;
    logic [31:0] cmd_ptr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [31:0] mem [64];
    int          mv_cnt = 0;
    int          nx = 0;
    logic [31:0] lg_addr [4];
    logic [15:0] lg_len [4];
    logic [1:0]  lg_code [4];

    always #2 clk = ~clk;

    desc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_code(xfer_code), .xfer_addr(xfer_addr),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_resid(xfer_resid),
        .status(status), .cmd_ptr(cmd_ptr)
    );

    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    // data mover model: done after four request cycles, residual = len - 5
    always @(posedge clk) begin
        if (!rst_n) begin
            mv_cnt <= 0; xfer_done <= 1'b0; nx <= 0;
        end else if (xfer_done) begin
            xfer_done <= 1'b0; mv_cnt <= 0;
        end else if (xfer_req) begin
            if (mv_cnt == 3) begin
                xfer_done  <= 1'b1;
                xfer_resid <= xfer_len - 16'd5;
                if (nx < 4) begin
                    lg_addr[nx] <= xfer_addr; lg_len[nx] <= xfer_len; lg_code[nx] <= xfer_code;
                end
                nx <= nx + 1;
            end else mv_cnt <= mv_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input logic [3:0] code, input logic [2:0] key,
                                       input logic [1:0] br, input logic [15:0] len);
        return {code, 1'b0, key, 4'b0000, br, 2'b00, len};
    endfunction

    task automatic do_reset();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic run_wait();
        @(negedge clk); run_req = 1'b1;
        @(negedge clk); run_req = 1'b0;
        for (int i = 0; i < 2000 && status[10]; i++) @(negedge clk);
    endtask

    // {br_mode, mask, value, status_low, taken}
    localparam logic [26:0] VEC [8] = '{
        {2'b00, 8'hFF, 8'hFF, 8'hFF, 1'b0},
        {2'b11, 8'h00, 8'h00, 8'h00, 1'b1},
        {2'b01, 8'h0F, 8'h05, 8'h05, 1'b1},
        {2'b01, 8'h0F, 8'h05, 8'h07, 1'b0},
        {2'b10, 8'h0F, 8'h05, 8'h07, 1'b1},
        {2'b10, 8'h0F, 8'h05, 8'h05, 1'b0},
        {2'b01, 8'h00, 8'hAA, 8'h03, 1'b1},
        {2'b10, 8'hF0, 8'h30, 8'h3C, 1'b0}
    };

    initial begin
        int seen;
        // R1 reset state
        do_reset();
        chk("R1 status", {16'h0, status}, 32'h0);
        chk("R1 cmd_ptr", cmd_ptr, 32'h0);
        chk("R1 idle outputs", {30'h0, mem_req, xfer_req}, 32'h0);

        // R6 R7 R8 R5: branch table, NOP at 0x00, STOP at 0x10 and 0x80
        for (int v = 0; v < 8; v++) begin
            do_reset();
            mem[0]  = cw(4'd6, 3'd0, VEC[v][26:25], 16'h0);
            mem[2]  = 32'h0000_0080;
            mem[3]  = 32'h0000_BEEF;
            mem[4]  = cw(4'd7, 3'd0, 2'b00, 16'h0);
            mem[32] = cw(4'd7, 3'd0, 2'b00, 16'h0);
            if (VEC[v][8:1] != 8'h00) wr_reg(2'd0, {24'h0, VEC[v][8:1]});
            wr_reg(2'd1, {8'hA5, VEC[v][24:17], 8'h5A, VEC[v][16:9]});
            run_wait();
            chk($sformatf("R8 R6 R7 branch vec %0d ptr", v), cmd_ptr,
                VEC[v][0] ? 32'h80 : 32'h10);
            chk($sformatf("R5 nop writeback vec %0d", v), mem[3],
                {16'h0400 | {8'h0, VEC[v][8:1]}, 16'hBEEF});
            chk($sformatf("R9 stop idle vec %0d", v), {16'h0, status}, {24'h0, VEC[v][8:1]});
        end

        // R2 R3 R4 R7 R12: two transfers then branch to STOP at 0x40
        do_reset();
        mem[0]  = cw(4'd0, 3'd0, 2'b00, 16'h0040);
        mem[1]  = 32'h1234_0000;
        mem[4]  = cw(4'd3, 3'd0, 2'b11, 16'h0020);
        mem[5]  = 32'h0000_5000;
        mem[6]  = 32'h0000_0040;
        mem[16] = cw(4'd7, 3'd0, 2'b00, 16'h0);
        @(negedge clk); run_req = 1'b1;
        @(negedge clk); run_req = 1'b0;
        chk("R2 active after start", {31'h0, status[10]}, 32'h1);
        chk("R2 first fetch address", mem_addr, 32'h0);
        for (int i = 0; i < 100 && !xfer_req; i++) @(negedge clk);
        wr_reg(2'd2, 32'h0000_00C0);   // R12: must be ignored while active
        for (int i = 0; i < 2000 && status[10]; i++) @(negedge clk);
        chk("R3 xfer count", nx, 2);
        chk("R3 first addr", lg_addr[0], 32'h1234_0000);
        chk("R3 first len", {16'h0, lg_len[0]}, 32'h40);
        chk("R3 second code", {30'h0, lg_code[1]}, 32'h3);
        chk("R3 second addr", lg_addr[1], 32'h5000);
        chk("R4 first writeback", mem[3], 32'h0400_003B);
        chk("R4 second writeback", mem[7], 32'h0400_001B);
        chk("R7 R12 final ptr", cmd_ptr, 32'h40);
        chk("R9 status after stop", {16'h0, status}, 32'h0);
        chk("R9 stop not written", mem[19], 32'h0);

        // R10 illegal code
        do_reset();
        mem[0] = cw(4'd9, 3'd0, 2'b00, 16'h0);
        run_wait();
        chk("R10 illegal dead", {16'h0, status}, 32'h0800);
        seen = 0;
        @(negedge clk); run_req = 1'b1;
        @(negedge clk); run_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (mem_req) seen++;
            @(negedge clk);
        end
        chk("R10 run ignored when dead", seen, 0);
        chk("R10 still dead", {16'h0, status}, 32'h0800);

        // R10 nonzero key on a transfer command
        do_reset();
        mem[0] = cw(4'd1, 3'd3, 2'b00, 16'h0010);
        run_wait();
        chk("R10 key dead", {16'h0, status}, 32'h0800);
        chk("R10 key no transfer", nx, 0);

        // R11 status OR rule and WAKE
        do_reset();
        wr_reg(2'd0, 32'h05);
        chk("R11 or first", {16'h0, status}, 32'h0005);
        wr_reg(2'd0, 32'h02);
        chk("R11 or second", {16'h0, status}, 32'h0007);
        wr_reg(2'd0, 32'h100);
        chk("R11 wake set", {16'h0, status}, 32'h0107);
        mem[0] = cw(4'd7, 3'd0, 2'b00, 16'h0);
        run_wait();
        chk("R11 wake cleared on fetch", {16'h0, status}, 32'h0007);
        chk("R9 stop ptr held", cmd_ptr, 32'h0);

        // R12 idle writes take effect
        wr_reg(2'd2, 32'h0000_0030);
        chk("R12 ptr write idle", cmd_ptr, 32'h30);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule